// File: doc/BRIEF.md
# Legacy INTx Level-to-Pulse Aggregator

This block merges four level-sensitive legacy interrupt inputs into a single pulse output for an interrupt controller that only detects edges. Each source has an enable bit and a sticky pending bit. Software reads the pending bits in one access, acknowledges a source by writing a one to its bit in a clear register, and then writes an end-of-interrupt register. In level-recovery mode, that end-of-interrupt write fires a new output pulse when any enabled source is still high. A level that stays asserted after service is therefore never lost on the edge line.

A mode input selects a reduced edge-only behaviour. In that mode, each enabled source produces one pulse when it asserts and one when it deasserts, and end-of-interrupt writes have no effect. The register port is a simple single-cycle write strobe with address and data, plus a combinational read data output.

Top module: `intx_pulse_agg`

## Requirements
- R1: The enable register at offset 0x100 holds bits [3:0] and reads back what was written. The pending register at offset 0x500 is read-only. Every other offset reads zero. Bit i of every register belongs to source `irq_lvl[i]`, with INTA on bit 0.
- R2: A pending bit is set on the rising edge of its source whether or not the source is enabled.
- R3: A pending bit stays set after its source drops. Writing a one to bit i at offset 0x700 clears it. A rising edge in the same cycle as the clear wins, and the bit stays set.
- R4: The rising edge of an enabled source drives `irq_pulse` high for the one cycle after the edge is sampled. This holds in both modes.
- R5: With `eoi_mode_en`=1, a falling edge produces no pulse. A source held high produces no further pulse unless an end-of-interrupt write occurs.
- R6: With `eoi_mode_en`=1, a write of any data to offset 0x010 pulses the output in the next cycle if any enabled source is high. If no enabled source is high, the write produces no pulse.
- R7: With `eoi_mode_en`=0, the falling edge of an enabled source pulses the output, and writes to offset 0x010 are ignored.
- R8: A source whose enable bit is clear never causes a pulse, either by its own edges or through an end-of-interrupt write.
- R9: Events from several sources in the same cycle merge into one pulse that is a single clock wide.
- R10: Reset clears all enable and pending bits and holds `irq_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoi_mode_en | input | 1 | 1: level recovery through end-of-interrupt, 0: edge-only pulses |
| irq_lvl | input | 4 | Level interrupt sources, bit 0 = INTA ... bit 3 = INTD |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Read data for `addr` (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions take two things for granted. First, `irq_lvl` is already synchronous to `clk`. Second, `eoi_mode_en` is quasi-static: it changes only at clock boundaries and is sampled like the other inputs. Each cycle carries at most one register write. The stimulus changes levels, the mode and register accesses only at the falling clock edge. It includes level changes on several sources in the same cycle, end-of-interrupt writes with enabled, disabled and absent sources, and a clear that collides with a new rising edge.

// File: rtl/intx_pkg.sv
// Package: shared constants and the mode type of the INTx pulse aggregator.
// Assumes byte offsets fit the 12-bit register address.
package intx_pkg;
    localparam int NUM_SRC = 4;
    localparam int ADDR_W  = 12;

    localparam logic [11:0] OFS_EOI    = 12'h010;
    localparam logic [11:0] OFS_ENABLE = 12'h100;
    localparam logic [11:0] OFS_STATUS = 12'h500;
    localparam logic [11:0] OFS_CLEAR  = 12'h700;

    typedef enum logic {
        AGG_EDGE_ONLY = 1'b0,
        AGG_LEVEL_EOI = 1'b1
    } agg_mode_e;
endpackage

// File: rtl/intx_edge_detect.sv
// Module: per-source rising/falling edge detector.
// Assumes the levels are already synchronous to clk; the history resets low,
// so a source high at reset release is seen as a rising edge.
module intx_edge_detect #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] lvl_d;

    // Hold last sampled level of each source.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '0;
        else        lvl_d <= lvl;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign rise[i] = lvl[i] & ~lvl_d[i];
        assign fall[i] = ~lvl[i] & lvl_d[i];
    end
endmodule

// File: rtl/intx_regs.sv
// Module: register file with enable, sticky pending, write-one-to-clear
// and an end-of-interrupt strobe. Assumes one write per cycle; read data
// is combinational from addr.
module intx_regs #(
    parameter int N  = 4,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    input  logic [N-1:0]  rise,
    output logic [N-1:0]  rdata,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  stat_q,
    output logic          eoi_wr
);
    localparam logic [AW-1:0] A_EOI = AW'(intx_pkg::OFS_EOI);
    localparam logic [AW-1:0] A_ENA = AW'(intx_pkg::OFS_ENABLE);
    localparam logic [AW-1:0] A_STA = AW'(intx_pkg::OFS_STATUS);
    localparam logic [AW-1:0] A_CLR = AW'(intx_pkg::OFS_CLEAR);

    logic         wr_ena;
    logic         wr_clr;
    logic [N-1:0] clr_vec;

    assign wr_ena  = wr_en && (addr == A_ENA);
    assign wr_clr  = wr_en && (addr == A_CLR);
    assign eoi_wr  = wr_en && (addr == A_EOI);
    assign clr_vec = wr_clr ? wdata : '0;

    // Enable register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_ena) en_q <= wdata;
    end

    // Pending register: set by rising edge, cleared by write-one, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | rise;
    end

    // Read mux: enable and pending readable, all else zero.
    always_comb begin
        if (addr == A_ENA)      rdata = en_q;
        else if (addr == A_STA) rdata = stat_q;
        else                    rdata = '0;
    end
endmodule

// File: rtl/intx_pulse_gen.sv
// Module: forms the single one-cycle output pulse from masked events.
// Assumes the mode is quasi-static; all triggers in one cycle merge.
module intx_pulse_gen #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  intx_pkg::agg_mode_e mode,
    input  logic [N-1:0]        rise,
    input  logic [N-1:0]        fall,
    input  logic [N-1:0]        lvl,
    input  logic [N-1:0]        en,
    input  logic                eoi_wr,
    output logic                pulse_q
);
    logic assert_hit;
    logic deassert_hit;
    logic retrigger;
    logic fire;

    assign assert_hit   = |(rise & en);
    assign deassert_hit = |(fall & en);
    assign retrigger    = eoi_wr && |(lvl & en);

    // Select the second trigger source by mode.
    always_comb begin
        if (mode == intx_pkg::AGG_LEVEL_EOI) fire = assert_hit | retrigger;
        else                                 fire = assert_hit | deassert_hit;
    end

    // Register the merged trigger as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= fire;
    end
endmodule

// File: rtl/intx_pulse_agg.sv
// Module: top of the legacy INTx level-to-pulse aggregator.
// Assumes irq_lvl is synchronous to clk and eoi_mode_en is quasi-static.
module intx_pulse_agg #(
    parameter int N  = intx_pkg::NUM_SRC,
    parameter int AW = intx_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eoi_mode_en,
    input  logic [N-1:0]  irq_lvl,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  rdata,
    output logic          irq_pulse
);
    logic [N-1:0]        rise_w;
    logic [N-1:0]        fall_w;
    logic [N-1:0]        en_w;
    logic [N-1:0]        stat_w;
    logic                eoi_w;
    intx_pkg::agg_mode_e mode_w;

    assign mode_w = intx_pkg::agg_mode_e'(eoi_mode_en);

    intx_edge_detect #(.N(N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(irq_lvl), .rise(rise_w), .fall(fall_w)
    );

    intx_regs #(.N(N), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rise(rise_w), .rdata(rdata), .en_q(en_w), .stat_q(stat_w), .eoi_wr(eoi_w)
    );

    intx_pulse_gen #(.N(N)) u_pulse (
        .clk(clk), .rst_n(rst_n), .mode(mode_w), .rise(rise_w), .fall(fall_w),
        .lvl(irq_lvl), .en(en_w), .eoi_wr(eoi_w), .pulse_q(irq_pulse)
    );
endmodule

// File: rtl/intx_agg_checker.sv
// Checker: temporal properties of the aggregator, bound to the top.
// Keeps its own history of the source levels.
module intx_agg_checker #(
    parameter int N  = 4,
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eoi_mode_en,
    input logic [N-1:0]  irq_lvl,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          irq_pulse,
    input logic [N-1:0]  en_q,
    input logic [N-1:0]  stat_q
);
    logic [N-1:0] lvl_h;

    // Independent history of the source levels.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_h <= '0;
        else        lvl_h <= irq_lvl;
    end

    // R10: output low after a reset cycle
    p_reset_low_r10: assert property (@(posedge clk) !rst_n |=> !irq_pulse);

    // R4: enabled rise pulses next cycle
    p_rise_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |(irq_lvl & ~lvl_h & en_q) |=> irq_pulse);

    // R3: pending bits stay set without a clear write
    p_status_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == AW'(intx_pkg::OFS_CLEAR)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6: end-of-interrupt with an enabled high source retriggers
    p_eoi_retrig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_mode_en && wr_en && addr == AW'(intx_pkg::OFS_EOI) && |(irq_lvl & en_q)) |=> irq_pulse);

    // R7: edge-only mode pulses only on enabled level changes
    p_edge_only_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoi_mode_en && !(|((irq_lvl ^ lvl_h) & en_q))) |=> !irq_pulse);

    // R8: nothing enabled means no pulse
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |=> !irq_pulse);
endmodule

bind intx_pulse_agg intx_agg_checker #(.N(N), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .eoi_mode_en(eoi_mode_en), .irq_lvl(irq_lvl),
    .wr_en(wr_en), .addr(addr), .irq_pulse(irq_pulse), .en_q(en_w), .stat_q(stat_w)
);

// File: tb/test_intx_pulse_agg.sv
module test_intx_pulse_agg;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_EOI = 12'h010;
    localparam logic [11:0] A_ENA = 12'h100;
    localparam logic [11:0] A_STA = 12'h500;
    localparam logic [11:0] A_CLR = 12'h700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoi_mode_en = 1'b1;
    logic [3:0]  irq_lvl = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic [3:0]  rdata;
    logic        irq_pulse;

    typedef struct { logic exp; string tag; } item_t;
    item_t sb_q[$];

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    logic [3:0] m_lvl_d = '0, m_en = '0, m_stat = '0, cur = '0;
    logic       m_mode = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    intx_pulse_agg i_intx_pulse_agg (
        .clk(clk), .rst_n(rst_n), .eoi_mode_en(eoi_mode_en), .irq_lvl(irq_lvl),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_pulse(irq_pulse)
    );

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, expected pulse pushed to the scoreboard.
    task automatic step(input logic [3:0] lvl, input logic wr, input logic [11:0] a,
                        input logic [3:0] d, input string tag);
        logic [3:0] rise, fall, rd_exp;
        item_t it;
        @(negedge clk);
        irq_lvl = lvl; wr_en = wr; addr = a; wdata = d; eoi_mode_en = m_mode;
        cur = lvl;
        rise = lvl & ~m_lvl_d;
        fall = ~lvl & m_lvl_d;
        it.exp = (|(rise & m_en)) |
                 (m_mode ? (wr && a == A_EOI && |(lvl & m_en)) : |(fall & m_en));
        it.tag = tag;
        sb_q.push_back(it);
        if (!wr) begin
            rd_exp = (a == A_ENA) ? m_en : (a == A_STA) ? m_stat : 4'h0;
            #1;
            checks++;
            if (rdata !== rd_exp) begin
                errors++;
                $display("FAIL %s rdata@%h actual=%h expected=%h", tag, a, rdata, rd_exp);
            end
        end
        m_stat = (m_stat & ~((wr && a == A_CLR) ? d : 4'h0)) | rise;
        if (wr && a == A_ENA) m_en = d;
        m_lvl_d = lvl;
    endtask

    task automatic idle(input logic [11:0] a, input string tag);
        step(cur, 1'b0, a, 4'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; wr_en = 0; irq_lvl = '0; cur = '0;
        @(negedge clk);
        checks++;
        if (irq_pulse !== 1'b0) begin
            errors++; $display("FAIL R10 irq_pulse actual=%b expected=0", irq_pulse);
        end
        rst_n = 1;
        m_lvl_d = '0; m_en = '0; m_stat = '0;
    endtask

    // Monitor: compare each registered output with the scoreboard head.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (irq_pulse !== it.exp) begin
                    errors++;
                    $display("FAIL %s irq_pulse actual=%b expected=%b", it.tag, irq_pulse, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        idle(A_ENA, "R10");
        idle(A_STA, "R10");
        // R1: enable register write/read, other offsets read zero
        step(cur, 1, A_ENA, 4'hF, "R1");
        idle(A_ENA, "R1");
        idle(12'h304, "R1");
        // R4, R2: INTA rising edge
        step(4'b0001, 0, A_STA, 0, "R4");
        idle(A_STA, "R2");
        idle(A_STA, "R5");
        // R6: end-of-interrupt while INTA still high
        step(cur, 1, A_EOI, 4'h0, "R6");
        idle(A_STA, "R6");
        // R5, R3: drop INTA, no pulse, pending stays
        step(4'b0000, 0, A_STA, 0, "R5");
        idle(A_STA, "R3");
        step(cur, 1, A_EOI, 4'h5, "R6");
        idle(A_STA, "R6");
        step(cur, 1, A_CLR, 4'b0001, "R3");
        idle(A_STA, "R3");
        // R9: two sources rise together
        step(4'b0110, 0, A_STA, 0, "R9");
        idle(A_STA, "R9");
        idle(A_STA, "R9");
        // R8: only INTA enabled
        step(cur, 1, A_ENA, 4'b0001, "R8");
        step(4'b0000, 0, A_STA, 0, "R8");
        step(4'b1000, 0, A_STA, 0, "R8");
        idle(A_STA, "R2");
        step(cur, 1, A_EOI, 4'h0, "R8");
        idle(A_ENA, "R8");
        step(4'b1001, 0, A_STA, 0, "R4");
        idle(A_STA, "R4");
        // R3: clear colliding with a new rising edge
        step(4'b1000, 0, A_STA, 0, "R5");
        step(4'b1001, 1, A_CLR, 4'b1001, "R3");
        idle(A_STA, "R3");
        // R7: edge-only mode
        m_mode = 1'b0;
        step(cur, 1, A_ENA, 4'hF, "R7");
        idle(A_STA, "R7");
        step(4'b1000, 0, A_STA, 0, "R7");
        idle(A_STA, "R7");
        step(4'b1010, 0, A_STA, 0, "R7");
        step(cur, 1, A_EOI, 4'h0, "R7");
        idle(A_STA, "R7");
        step(4'b0101, 0, A_STA, 0, "R9");
        idle(A_STA, "R9");
        // R10: reset mid-run
        m_mode = 1'b1;
        do_reset();
        idle(A_ENA, "R10");
        idle(A_STA, "R10");
        @(negedge clk);
        @(negedge clk);
        summary();
    end
endmodule